// File: doc/BRIEF.md
# Auto-Reload Baud Rate Timer

This block is a 16-bit up-counter paired with a 16-bit reload register. It generates the bit-rate tick for a classic 8-bit microcontroller serial port. Each time the counter passes its all-ones value, it is loaded again from the reload register. In baud mode the counter advances once every two clocks. One output tick is issued for every sixteen overflows, so the tick rate is f_clk / (32 × (65536 − reload)). When neither clock select is set, the block is a plain auto-reload timer. In that mode it advances once every twelve clocks and reports overflow through a sticky flag.

A falling edge on an external trigger pin, when enabled, sets a flag of its own. In timer mode the same edge also forces a reload. In baud mode it only raises the flag, so the pin can act as a spare interrupt source. Software programs the block through a plain write port: control, reload value, counter value and flag clear. The block has no data stream, so there is no valid/ready handshake. Every pin is plain control or status.

Top module: `baud_reload_timer`

## Requirements
- R1: Baud mode is active when control bit 2 (receive select) or bit 3 (transmit select) is 1. With run (control bit 0) set in baud mode, successive `baud_tick` pulses are exactly 32 × (65536 − reload) clocks apart.
- R2: When the counter steps from 0xFFFF, it is loaded from the reload register (address 1) instead of wrapping to zero.
- R3: An overflow in baud mode leaves `ovf_flag` clear and does not raise `irq`.
- R4: In timer mode (both selects 0) the counter steps once per 12 clocks. An overflow sets `ovf_flag` and produces no `baud_tick`. With reload 0xFFF0, the flag rises on the 192nd clock edge after the control write that sets run.
- R5: With ext-enable (control bit 1) set in baud mode, a falling edge on `ext_pin` sets `ext_flag` and leaves the counter value unchanged.
- R6: With ext-enable set in timer mode, a falling edge on `ext_pin` loads the counter from the reload register, even while run is clear.
- R7: With ext-enable clear, falling edges on `ext_pin` set no flag and cause no reload.
- R8: While run is set, writes to the reload register (address 1) and the counter (address 2) are ignored. Writes to control (address 0) always take effect.
- R9: `irq` is high when `ovf_flag` is set, or when `ext_flag` is set and irq-enable (control bit 4) is 1.
- R10: Writing address 3 with bit 0 set clears `ovf_flag`, and with bit 1 set clears `ext_flag`. A set in the same cycle takes priority over the clear.
- R11: After reset, `baud_tick`, both flags and `irq` are 0, `count_value` is 0 and run is clear.
- R12: `baud_tick` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 reload, 2 counter, 3 flag clear |
| wr_data | input | 16 | Write data |
| ext_pin | input | 1 | Asynchronous external trigger pin |
| baud_tick | output | 1 | One-clock bit-rate tick |
| ovf_flag | output | 1 | Sticky timer-mode overflow flag |
| ext_flag | output | 1 | Sticky external-edge flag |
| irq | output | 1 | Interrupt request |
| count_value | output | 16 | Current counter value |

## Verification
An external edge and a counter overflow can land in the same cycle. In baud mode this case must set the edge flag while leaving the reload path and the tick period alone. The bench provokes it by running with reload 0xFFFF, where every counter step overflows, and then dropping `ext_pin`. It judges the result by measuring the tick spacing, which must remain 32 clocks, and then reading `ext_flag` and `irq`. Ignored writes are judged the same way, through the measured period after a reload write made while the counter runs.

// File: rtl/baud_timer_pkg.sv
package baud_timer_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_RELOAD = 2'd1,
    ADDR_COUNT  = 2'd2,
    ADDR_CLEAR  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic irq_en;
    logic tx_sel;
    logic rx_sel;
    logic ext_en;
    logic run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/bt_pin_sync.sv
module bt_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_async};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign fall = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/bt_prescaler.sv
module bt_prescaler #(
  parameter int STATE_DIV = 2,
  parameter int MCYC_DIV  = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  output logic step
);
  localparam int MAXDIV = (MCYC_DIV > STATE_DIV) ? MCYC_DIV : STATE_DIV;
  localparam int PW     = (MAXDIV > 2) ? $clog2(MAXDIV) : 1;
  localparam logic [PW-1:0] LIM_FAST = PW'(STATE_DIV - 1);
  localparam logic [PW-1:0] LIM_SLOW = PW'(MCYC_DIV - 1);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] limit;

  assign limit = fast ? LIM_FAST : LIM_SLOW;
  assign step  = run && (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt_q <= '0;
    else if (step)      cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bt_counter.sv
module bt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             sw_load,
  input  logic [CNT_W-1:0] sw_data,
  input  logic             ext_load,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] value,
  output logic             ovf
);
  logic [CNT_W-1:0] cnt_q;

  assign ovf   = step && (&cnt_q);
  assign value = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (sw_load)        cnt_q <= sw_data;
    else if (ext_load || ovf) cnt_q <= reload;
    else if (step)           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bt_tick_div.sv
module bt_tick_div #(
  parameter int OVF_PER_TICK = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic ovf,
  output logic tick
);
  localparam int DW = (OVF_PER_TICK > 2) ? $clog2(OVF_PER_TICK) : 1;
  localparam logic [DW-1:0] LAST = DW'(OVF_PER_TICK - 1);

  logic [DW-1:0] cnt_q;
  logic          tick_q;
  logic          wrap;

  assign wrap = enable && ovf && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= wrap;
      if (!enable)    cnt_q <= '0;
      else if (wrap)  cnt_q <= '0;
      else if (ovf)   cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = tick_q;
endmodule

// File: rtl/baud_reload_timer.sv
module baud_reload_timer
  import baud_timer_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int STATE_DIV    = 2,
  parameter int MCYC_DIV     = 12,
  parameter int OVF_PER_TICK = 16,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             ext_pin,
  output logic             baud_tick,
  output logic             ovf_flag,
  output logic             ext_flag,
  output logic             irq,
  output logic [CNT_W-1:0] count_value
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic             ovf_flag_q, ext_flag_q;
  logic             baud_mode, ext_fall, ext_hit, step, ovf;
  logic             wr_ctrl, wr_reload, wr_count, wr_clear;

  assign baud_mode = ctrl_q.rx_sel | ctrl_q.tx_sel;
  assign wr_ctrl   = wr_en && (wr_addr == ADDR_CTRL);
  assign wr_reload = wr_en && (wr_addr == ADDR_RELOAD) && !ctrl_q.run;
  assign wr_count  = wr_en && (wr_addr == ADDR_COUNT)  && !ctrl_q.run;
  assign wr_clear  = wr_en && (wr_addr == ADDR_CLEAR);

  bt_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_async(ext_pin), .fall(ext_fall)
  );

  assign ext_hit = ext_fall && ctrl_q.ext_en;

  bt_prescaler #(.STATE_DIV(STATE_DIV), .MCYC_DIV(MCYC_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .fast(baud_mode), .step(step)
  );

  bt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step),
    .sw_load(wr_count), .sw_data(wr_data),
    .ext_load(ext_hit && !baud_mode), .reload(reload_q),
    .value(count_value), .ovf(ovf)
  );

  bt_tick_div #(.OVF_PER_TICK(OVF_PER_TICK)) u_div (
    .clk(clk), .rst_n(rst_n), .enable(baud_mode && ctrl_q.run),
    .ovf(ovf), .tick(baud_tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      reload_q   <= '0;
      ovf_flag_q <= 1'b0;
      ext_flag_q <= 1'b0;
    end else begin
      if (wr_ctrl)   ctrl_q   <= ctrl_t'(wr_data[CTRL_W-1:0]);
      if (wr_reload) reload_q <= wr_data;
      if (ovf && !baud_mode)           ovf_flag_q <= 1'b1;
      else if (wr_clear && wr_data[0]) ovf_flag_q <= 1'b0;
      if (ext_hit)                     ext_flag_q <= 1'b1;
      else if (wr_clear && wr_data[1]) ext_flag_q <= 1'b0;
    end
  end

  assign ovf_flag = ovf_flag_q;
  assign ext_flag = ext_flag_q;
  assign irq      = ovf_flag_q | (ext_flag_q & ctrl_q.irq_en);
endmodule

// File: rtl/baud_reload_timer_chk.sv
module baud_reload_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             baud_tick,
  input logic             ovf_flag,
  input logic             ext_flag,
  input logic             baud_mode,
  input logic             run,
  input logic             ext_en,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [CNT_W-1:0] reload
);
  p_tick_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |=> !baud_tick);

  p_tick_baud_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(baud_tick) |-> $past(baud_mode));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> !$past(baud_mode));

  p_reload_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wr_en && wr_addr == 2'd1) |=> $stable(reload));

  p_ext_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_flag) |-> $past(ext_en));
endmodule

bind baud_reload_timer baud_reload_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .ovf_flag(ovf_flag),
  .ext_flag(ext_flag), .baud_mode(baud_mode), .run(ctrl_q.run),
  .ext_en(ctrl_q.ext_en), .wr_en(wr_en), .wr_addr(wr_addr), .reload(reload_q)
);

// File: tb/baud_reload_timer_tb_top.sv
module baud_reload_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        ext_pin = 1'b1;
  logic        baud_tick, ovf_flag, ext_flag, irq;
  logic [15:0] count_value;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  baud_reload_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ext_pin(ext_pin), .baud_tick(baud_tick),
    .ovf_flag(ovf_flag), .ext_flag(ext_flag), .irq(irq),
    .count_value(count_value)
  );

  typedef struct packed {
    logic [15:0] reload;
    logic [4:0]  ctrl;
    logic [31:0] period;
  } vec_t;

  // ctrl bits: 0 run, 1 ext_en, 2 rx_sel, 3 tx_sel, 4 irq_en
  localparam vec_t VEC [5] = '{
    '{16'hFFFF, 5'b00101, 32'd32},
    '{16'hFFFE, 5'b01001, 32'd64},
    '{16'hFFF0, 5'b01101, 32'd512},
    '{16'hFF00, 5'b00101, 32'd8192},
    '{16'hFFFD, 5'b01001, 32'd96}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure(output int period, output bit single);
    int c = 0;
    while (!baud_tick && c < 20000) begin @(negedge clk); c++; end
    @(negedge clk);
    single = !baud_tick;
    period = 1;
    while (!baud_tick && period < 20000) begin @(negedge clk); period++; end
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
    end
  end

  initial begin
    int  p;
    bit  s;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    // R11 reset state
    check("R11 tick", baud_tick, 0);
    check("R11 flags", {ovf_flag, ext_flag, irq}, 0);
    check("R11 count", count_value, 0);

    // R1 R2 R3 R12 table of baud periods
    for (int k = 0; k < 5; k++) begin
      wr(2'd0, 16'd0);
      wr(2'd1, VEC[k].reload);
      wr(2'd2, VEC[k].reload);
      wr(2'd0, {11'd0, VEC[k].ctrl});
      measure(p, s);
      check("R1 R2 period", p, VEC[k].period);
      check("R12 single pulse", s, 1);
      check("R3 no ovf flag", {ovf_flag, irq}, 0);
    end

    // R8 writes while running ignored (reload 0xFFFF still running)
    wr(2'd0, 16'd0);
    wr(2'd1, 16'hFFFF);
    wr(2'd0, 16'h0005);
    wr(2'd1, 16'h0000);
    wr(2'd2, 16'h1234);
    measure(p, s);
    check("R8 period after locked write", p, 32);

    // Simultaneous edge and overflow in baud mode: R5 R9
    wr(2'd0, 16'h0007);
    ext_pin = 1'b0;
    measure(p, s);
    check("R5 period with edge", p, 32);
    check("R5 ext flag", ext_flag, 1);
    check("R9 irq disabled", irq, 0);
    wr(2'd0, 16'h0017);
    check("R9 irq enabled", irq, 1);
    ext_pin = 1'b1;

    // R10 clear
    wr(2'd3, 16'h0002);
    check("R10 ext clear", ext_flag, 0);

    // R6 timer mode reload on edge while stopped
    wr(2'd0, 16'h0002);
    wr(2'd1, 16'hABCD);
    wr(2'd2, 16'h0100);
    ext_pin = 1'b0; wait_cyc(5);
    check("R6 ext reload", count_value, 16'hABCD);
    ext_pin = 1'b1; wait_cyc(5);
    wr(2'd3, 16'h0003);

    // R5 baud mode edge no reload
    wr(2'd0, 16'h0006);
    wr(2'd2, 16'h0200);
    ext_pin = 1'b0; wait_cyc(5);
    check("R5 no reload", count_value, 16'h0200);
    check("R5 flag set", ext_flag, 1);
    ext_pin = 1'b1; wait_cyc(5);
    wr(2'd3, 16'h0002);

    // R7 edge ignored when disabled (timer mode)
    wr(2'd0, 16'h0000);
    ext_pin = 1'b0; wait_cyc(5);
    check("R7 no flag", ext_flag, 0);
    check("R7 no reload", count_value, 16'h0200);
    ext_pin = 1'b1; wait_cyc(5);

    // R4 timer mode overflow timing
    wr(2'd1, 16'hFFF0);
    wr(2'd2, 16'hFFF0);
    wr(2'd0, 16'h0001);
    wait_cyc(190);
    check("R4 flag not yet", ovf_flag, 0);
    wait_cyc(3);
    check("R4 flag set", ovf_flag, 1);
    check("R9 irq from ovf", irq, 1);
    check("R2 reloaded", count_value, 16'hFFF0);
    p = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (baud_tick) p++; end
    check("R4 no tick", p, 0);
    wr(2'd0, 16'h0000);
    wr(2'd3, 16'h0001);
    check("R10 ovf clear", ovf_flag, 0);

    done = 1;
    report();
  end
endmodule